// File: doc/BRIEF.md
# Multi-mode parallel host bus interface

This block connects an 8-bit microcontroller bus to a bank of byte-wide registers inside the chip. It supports three bus protocols and detects at run time which one the host uses. The level or activity on the address-latch-enable input decides. If the input stays high, the block uses a data-strobe protocol with a read/write direction line. If it stays low, the block uses separate active-low read and write strobes, with the address on its own bus. The first edge seen on the input switches the block to a multiplexed protocol, where the address and the data share one bus. That choice holds until the next reset.

Register addressing is set by a static pin. In direct addressing, the bus address selects one of the 256 registers. In indirect addressing, only address bit 0 matters. It chooses between a pointer register and a data window. Window accesses go to the register the pointer names. This lets a host with only two address lines reach the whole bank.

The host control pins are synchronised into the block clock. A write takes effect when the write strobe ends. The data bus is split into input, output and output-enable signals, so the pad ring can build the tri-state buffer.

Top module: `hbus_bridge`

## Requirements
- R1: If the latch-enable input is steady high when reset is released, the block uses strobe mode. `rd_n` is the direction line (1 = read, 0 = write) and `wr_n` is the active-low data strobe. The address comes from `addr`.
- R2: If the latch-enable input is steady low when reset is released, the block uses separate-strobe mode. `rd_n` low is a read, `wr_n` low is a write, and the address comes from `addr`.
- R3: Once start-up has finished, a rising or falling edge on the latch-enable input switches the block to multiplexed mode. The switch happens within a few clocks, before the next bus access.
- R4: Multiplexed mode stays in force whatever the later latch-enable level. Only reset leaves it, and after reset the level-based choice is made again.
- R5: In multiplexed mode, the register address is taken from `ad_in` on the falling edge of the latch-enable input. The `addr` pins are ignored. Reads and writes then use the `rd_n`/`wr_n` strobes.
- R6: With `amode` = 0, the bus address selects the register directly, for both reads and writes.
- R7: With `amode` = 1, only address bit 0 is decoded. All other address bits are ignored.
- R8: With `amode` = 1, address bit 0 = 0 reads and writes the pointer register. Address bit 0 = 1 reads and writes the register whose number is held in the pointer.
- R9: `ad_oe` is high only while `cs_n` is low and the read condition of the current mode holds. Otherwise it is low, including during writes and while idle.
- R10: A write is committed when the write strobe ends, using the data on `ad_in` at that time. Strobe activity while `cs_n` is high changes no register.
- R11: Reset clears all 256 registers and the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| amode | input | 1 | Addressing: 0 direct, 1 indirect |
| ale | input | 1 | Address-latch-enable; level or edges choose the bus protocol |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Read strobe, or read/write direction in strobe mode |
| wr_n | input | 1 | Write strobe, or data strobe in strobe mode |
| addr | input | 8 | Separate address bus (non-multiplexed modes) |
| ad_in | input | 8 | Data bus input; carries the address phase in multiplexed mode |
| ad_out | output | 8 | Data bus output value |
| ad_oe | output | 1 | Data bus output enable (high = drive) |

## Verification
The bench uses the default parameters: 8-bit address and data, and two synchroniser stages. This makes the full 256-register bank reachable, including address 0xFF and a pointer value that reaches past any small window. Every mode transition is exercised: steady high, steady low, switching to multiplexed from each, and leaving multiplexed mode by reset. A behavioural model that tracks mode, pointer and register contents is compared against the bus outputs on every clock.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  typedef enum logic [1:0] {
    MODE_PEND = 2'd0,
    MODE_STRB = 2'd1,
    MODE_SEPR = 2'd2,
    MODE_MUXD = 2'd3
  } bus_mode_e;

  // read condition for a given protocol, from active-low pins
  function automatic logic rd_req(bus_mode_e m, logic cs_n, logic rd_n, logic wr_n);
    case (m)
      MODE_STRB:            rd_req = !cs_n && !wr_n &&  rd_n;
      MODE_SEPR, MODE_MUXD: rd_req = !cs_n && !rd_n &&  wr_n;
      default:              rd_req = 1'b0;
    endcase
  endfunction

  // write condition for a given protocol, from active-low pins
  function automatic logic wr_req(bus_mode_e m, logic cs_n, logic rd_n, logic wr_n);
    case (m)
      MODE_STRB:            wr_req = !cs_n && !wr_n && !rd_n;
      MODE_SEPR, MODE_MUXD: wr_req = !cs_n && !wr_n &&  rd_n;
      default:              wr_req = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/hbus_mode_det.sv
module hbus_mode_det
  import hbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ale_s,
  output bus_mode_e mode,
  output logic      ale_fall
);

  localparam int STARTUP = SYNC_STAGES + 1;
  localparam int CW      = $clog2(STARTUP + 1);

  logic [CW-1:0] start_cnt;
  logic          started;
  logic          ale_q;
  logic          ale_edge;

  assign ale_edge = started && (ale_s != ale_q);
  assign ale_fall = started && ale_q && !ale_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_cnt <= '0;
      started   <= 1'b0;
      ale_q     <= 1'b0;
      mode      <= MODE_PEND;
    end else begin
      ale_q <= ale_s;
      if (!started) begin
        start_cnt <= start_cnt + 1'b1;
        if (start_cnt == CW'(STARTUP - 1)) begin
          started <= 1'b1;
          mode    <= ale_s ? MODE_STRB : MODE_SEPR;
        end
      end else if (ale_edge) begin
        mode <= MODE_MUXD;
      end
    end
  end

  assert_edge_to_mux_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale_edge |=> mode == MODE_MUXD);

  assert_mux_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_MUXD |=> mode == MODE_MUXD);

  assert_strobe_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STRB && ale_s == ale_q) |=> mode == MODE_STRB);

  assert_separate_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SEPR && ale_s == ale_q) |=> mode == MODE_SEPR);

endmodule

// File: rtl/hbus_strobe_dec.sv
module hbus_strobe_dec
  import hbus_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bus_mode_e mode,
  input  logic      cs_n_s,
  input  logic      rd_n_s,
  input  logic      wr_n_s,
  input  logic      cs_n,
  input  logic      rd_n,
  input  logic      wr_n,
  output logic      wr_commit,
  output logic      rd_en
);

  logic wr_now;
  logic wr_q;

  assign wr_now    = wr_req(mode, cs_n_s, rd_n_s, wr_n_s);
  assign wr_commit = wr_q && !wr_now;
  assign rd_en     = rd_req(mode, cs_n, rd_n, wr_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_now;
  end

  assert_commit_needs_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !$past(cs_n_s));

endmodule

// File: rtl/hbus_regbank.sv
module hbus_regbank #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          amode,
  input  logic          commit,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr;

  // register index named by an access in either addressing scheme
  function automatic logic [AW-1:0] target(logic ind, logic [AW-1:0] a, logic [AW-1:0] p);
    target = ind ? p : a;
  endfunction

  function automatic logic hits_ptr(logic ind, logic [AW-1:0] a);
    hits_ptr = ind && !a[0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      ptr <= '0;
    end else if (commit) begin
      if (hits_ptr(amode, waddr)) ptr <= AW'(wdata);
      else                        mem[target(amode, waddr, ptr)] <= wdata;
    end
  end

  always_comb begin
    if (hits_ptr(amode, raddr)) rdata = DW'(ptr);
    else                        rdata = mem[target(amode, raddr, ptr)];
  end

  assert_direct_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !amode) |=> mem[$past(waddr)] == $past(wdata));

  assert_ptr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && amode && !waddr[0]) |=> ptr == AW'($past(wdata)));

  assert_window_hold_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && amode && waddr[0]) |=> $stable(ptr));

endmodule

// File: rtl/hbus_bridge.sv
module hbus_bridge
  import hbus_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          amode,
  input  logic          ale,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe
);

  localparam int NCTL = 4;

  logic [NCTL-1:0] ctl_s;
  logic            ale_s, cs_n_s, rd_n_s, wr_n_s;
  bus_mode_e       mode;
  logic            ale_fall;
  logic            wr_commit;
  logic            rd_en;
  logic [AW-1:0]   alat;
  logic [AW-1:0]   eff_addr;
  logic [DW-1:0]   rdata;

  hbus_sync #(
    .WIDTH  (NCTL),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b0111)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ale, cs_n, rd_n, wr_n}),
    .q    (ctl_s)
  );

  assign {ale_s, cs_n_s, rd_n_s, wr_n_s} = ctl_s;

  hbus_mode_det #(.SYNC_STAGES(SYNC_STAGES)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale_s   (ale_s),
    .mode    (mode),
    .ale_fall(ale_fall)
  );

  hbus_strobe_dec u_strb (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .cs_n_s   (cs_n_s),
    .rd_n_s   (rd_n_s),
    .wr_n_s   (wr_n_s),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .wr_commit(wr_commit),
    .rd_en    (rd_en)
  );

  // address phase of the multiplexed protocol
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        alat <= '0;
    else if (ale_fall) alat <= AW'(ad_in);
  end

  assign eff_addr = (mode == MODE_MUXD) ? alat : addr;

  hbus_regbank #(.AW(AW), .DW(DW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .amode (amode),
    .commit(wr_commit),
    .waddr (eff_addr),
    .wdata (ad_in),
    .raddr (eff_addr),
    .rdata (rdata)
  );

  assign ad_oe  = rd_en;
  assign ad_out = rd_en ? rdata : '0;

  assert_oe_needs_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !cs_n);

  assert_mux_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MUXD && ale_fall) |=> alat == AW'($past(ad_in)));

  assert_latch_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_fall |=> $stable(alat));

endmodule

// File: tb/tb_hbus_bridge.sv
module tb_hbus_bridge;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       amode = 1'b0;
  logic       ale = 1'b0;
  logic       cs_n = 1'b1;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] addr = 8'h00;
  logic [7:0] ad_in = 8'h00;
  logic [7:0] ad_out;
  logic       ad_oe;

  always #2 clk = ~clk;

  hbus_bridge dut (
    .clk(clk), .rst_n(rst_n), .amode(amode), .ale(ale), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe)
  );

  // reference model: 1 strobe, 2 separate, 3 multiplexed
  int         m_mode = 2;
  logic [7:0] m_mem [256];
  logic [7:0] m_ptr = 8'h00;
  logic [7:0] m_alat = 8'h00;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;
  string      cur_req = "R9";

  function automatic bit m_rd_cond();
    if (m_mode == 1) return !cs_n && !wr_n && rd_n;
    return !cs_n && !rd_n && wr_n;
  endfunction

  function automatic logic [7:0] m_read(logic [7:0] a);
    if (!amode) return m_mem[a];
    if (a[0] == 1'b0) return m_ptr;
    return m_mem[m_ptr];
  endfunction

  function automatic void m_write(logic [7:0] a, logic [7:0] d);
    if (!amode)           m_mem[a] = d;
    else if (a[0] == 1'b0) m_ptr = d;
    else                  m_mem[m_ptr] = d;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      logic [7:0] ea;
      bit eo;
      eo = m_rd_cond();
      chk(ad_oe === eo, "R9 oe", int'(ad_oe), int'(eo));
      if (eo && ad_oe === 1'b1) begin
        ea = (m_mode == 3) ? m_alat : addr;
        chk(ad_out === m_read(ea), cur_req, int'(ad_out), int'(m_read(ea)));
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(bit lvl);
    tick(1);
    rst_n = 1'b0; ale = lvl; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    m_ptr = 8'h00; m_alat = 8'h00;
    m_mode = lvl ? 1 : 2;
    tick(4);
    rst_n = 1'b1;
    tick(8);
  endtask

  task automatic set_ale(bit v, logic [7:0] adv);
    ad_in = adv;
    ale = v;
    m_mode = 3;
    if (!v) m_alat = adv;
    tick(8);
  endtask

  task automatic bus_wr(logic [7:0] a, logic [7:0] d, bit use_cs);
    if (m_mode == 3) begin
      set_ale(1'b1, a);
      set_ale(1'b0, a);
      addr = ~a;
    end else begin
      addr = a;
    end
    ad_in = d;
    if (m_mode == 1) begin
      cs_n = !use_cs; rd_n = 1'b0;
      tick(2);
      wr_n = 1'b0;
      tick(5);
      chk(ad_oe === 1'b0, "R9 write", int'(ad_oe), 0);
      wr_n = 1'b1;
      tick(5);
      cs_n = 1'b1; rd_n = 1'b1;
    end else begin
      cs_n = !use_cs;
      tick(2);
      wr_n = 1'b0;
      tick(5);
      chk(ad_oe === 1'b0, "R9 write", int'(ad_oe), 0);
      wr_n = 1'b1;
      tick(5);
      cs_n = 1'b1;
    end
    if (use_cs) m_write((m_mode == 3) ? m_alat : a, d);
    tick(3);
  endtask

  task automatic bus_rd(logic [7:0] a, string req);
    logic [7:0] ea;
    cur_req = req;
    if (m_mode == 3) begin
      set_ale(1'b1, a);
      set_ale(1'b0, a);
      addr = ~a;
    end else begin
      addr = a;
    end
    ea = (m_mode == 3) ? m_alat : a;
    cs_n = 1'b0;
    if (m_mode == 1) begin rd_n = 1'b1; wr_n = 1'b0; end
    else             begin rd_n = 1'b0; end
    tick(5);
    chk(ad_oe === 1'b1, req, int'(ad_oe), 1);
    chk(ad_out === m_read(ea), req, int'(ad_out), int'(m_read(ea)));
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    tick(3);
    cur_req = "R9";
  endtask

  // read without an address phase (multiplexed mode keeps the latched address)
  task automatic plain_rd(logic [7:0] pin_a, logic [7:0] exp, string req);
    addr = pin_a;
    cs_n = 1'b0; rd_n = 1'b0;
    tick(5);
    chk(ad_oe === 1'b1, req, int'(ad_oe), 1);
    chk(ad_out === exp, req, int'(ad_out), int'(exp));
    cs_n = 1'b1; rd_n = 1'b1;
    tick(3);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    // R2 / R11: steady low level, separate strobes
    do_reset(1'b0);
    bus_rd(8'h00, "R11");
    bus_rd(8'hFF, "R11");
    bus_wr(8'h12, 8'hA5, 1'b1);
    bus_wr(8'hFF, 8'h3C, 1'b1);
    bus_rd(8'h12, "R2");
    bus_rd(8'hFF, "R6");
    // R10: strobes without chip select change nothing
    bus_wr(8'h12, 8'h00, 1'b0);
    bus_rd(8'h12, "R10");
    // R7 / R8: indirect window
    amode = 1'b1;
    bus_rd(8'h00, "R11 ptr");
    bus_wr(8'hFE, 8'h40, 1'b1);
    bus_rd(8'h5A, "R8 ptr");
    bus_wr(8'h37, 8'h99, 1'b1);
    bus_rd(8'hC3, "R7");
    bus_wr(8'hA0, 8'h12, 1'b1);
    bus_rd(8'h01, "R8 window");
    amode = 1'b0;
    bus_rd(8'h40, "R8");
    // R3: rising edge selects multiplexed, address from latch (still 0)
    set_ale(1'b1, 8'h00);
    plain_rd(8'h12, 8'h00, "R3");
    // R5: address phase on ad_in, addr pins ignored
    bus_wr(8'h55, 8'h77, 1'b1);
    bus_rd(8'h55, "R5");
    bus_rd(8'h12, "R5");
    // R4: long low level keeps multiplexed mode
    tick(20);
    plain_rd(8'h55, 8'hA5, "R4");
    // R1: steady high level, strobe protocol
    do_reset(1'b1);
    bus_rd(8'h12, "R11");
    bus_wr(8'h21, 8'h6E, 1'b1);
    bus_rd(8'h21, "R1");
    bus_wr(8'h21, 8'h11, 1'b0);
    bus_rd(8'h21, "R10");
    // R3 from strobe mode: falling edge latches and switches
    set_ale(1'b0, 8'h21);
    plain_rd(8'h00, 8'h6E, "R3");
    bus_wr(8'h80, 8'hC9, 1'b1);
    bus_rd(8'h80, "R5");
    // R4: reset leaves multiplexed mode
    do_reset(1'b0);
    bus_wr(8'h33, 8'h5D, 1'b1);
    plain_rd(8'h33, 8'h5D, "R4");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule